// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable integer and marks the end of every divide period with one output pulse. It is intended for the feedback path of a frequency synthesizer, where that pulse feeds the phase comparator. The division uses a dual-modulus prescaler that runs by 8 or by 9. A swallow count decides how many prescaler periods use the longer modulus, and a main count decides how many prescaler periods make up one full divide period. The overall ratio is therefore eight times the main count plus the swallow count.

The 11-bit divide word is taken in only at a period boundary, so a period that has already started always finishes with the old ratio. A word is legal when the main count is nonzero and the swallow count does not exceed it. An illegal word parks the block in a hold state, where it raises a configuration flag and emits no pulses. It leaves that state on the first clock that presents a legal word.

The controller is a three-state machine. ST_SWALLOW runs the prescaler by 9. ST_PLAIN runs it by 8. ST_HOLD means the latched word is illegal. It moves between states as follows:
- load into ST_SWALLOW when the new swallow count is nonzero;
- load into ST_PLAIN when the new swallow count is zero;
- move from ST_SWALLOW to ST_PLAIN when the last long prescaler period ends;
- load into ST_HOLD when the new word is illegal.

A load takes place on reset, at the end of a divide period, and on every clock spent in ST_HOLD.

Top module: `pswallow_div`

## Requirements
- R1: The swallow count A is taken from div_word bits [2:0] and the main count M from div_word bits [10:3], both plain binary. With a legal word, consecutive pulse_out pulses are exactly R = 8*M + A clocks apart.
- R2: pulse_out is high for exactly one clock per divide period.
- R3: Let E be the last rising edge at which rst is high. The first pulse is high in the clock period that follows edge E+R-1.
- R4: With A=0 the spacing is exactly 8*M. With A=M every prescaler period is long and the spacing is 9*M.
- R5: A word with M=0 or A>M is illegal. From the clock after the edge that latches it, cfg_bad is high and pulse_out stays low for as long as no legal word is latched.
- R6: div_word is sampled only at the edge that ends a pulse clock. A change made earlier leaves the period in progress at its old length, and the next period uses the new ratio.
- R7: While cfg_bad is high, div_word is sampled at every edge. Once a legal word is latched, cfg_bad falls in the next clock and the first pulse follows with the same timing as after reset.
- R8: Reset is synchronous and active high. pulse_out is low while rst is high, and the reset edge latches div_word and starts a fresh period.
- R9: The extreme ratios are reached: 8 (M=1, A=0), 9 (M=1, A=1) and 2047 (M=255, A=7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | 11 | Divide word: main count in [10:3], swallow count in [2:0] |
| pulse_out | output | 1 | One-clock pulse at the end of each divide period |
| cfg_bad | output | 1 | High while the latched divide word is illegal |

## Verification
A fault in the prescaler, the swallow counter or the main counter shows up at the port as a pulse spacing that is not exactly 8*M + A. It is therefore visible within one divide period, at most 2047 clocks. A wrong state transition shows the same way. Leaving ST_SWALLOW too early or too late shortens or stretches the spacing by the number of misplaced long periods. A hold-state fault shows at once as a pulse while cfg_bad is high, or as a cfg_bad level that disagrees with the last word sampled at a boundary. A word taken in at the wrong time shows as a period that does not match the ratio in force at the preceding pulse.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    // Controller states: prescaler by 9, prescaler by 8, illegal word parked
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_PLAIN   = 2'd2
    } div_state_t;

endpackage

// File: rtl/pswallow_cfg_chk.sv
module pswallow_cfg_chk #(
    parameter int A_W = 3,
    parameter int M_W = 8
) (
    input  logic [A_W-1:0] a_val,
    input  logic [M_W-1:0] m_val,
    output logic           word_ok
);
    localparam int CW = (A_W > M_W) ? A_W : M_W;

    logic [CW-1:0] a_x;
    logic [CW-1:0] m_x;

    assign a_x = CW'(a_val);
    assign m_x = CW'(m_val);

    // legal: main count nonzero and swallow count not above it
    assign word_ok = (m_val != '0) && (a_x <= m_x);

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
    parameter int A_W = 3
) (
    input  logic clk,
    input  logic restart,
    input  logic long_mode,
    output logic tick
);
    localparam int N  = 1 << A_W;
    localparam int CW = A_W + 1;

    logic [CW-1:0] cnt;

    // count down to zero; a period lasts N+1 clocks in long mode, N otherwise
    always_ff @(posedge clk) begin
        if (restart || tick) begin
            cnt <= long_mode ? CW'(N) : CW'(N - 1);
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/pswallow_ctrl.sv
module pswallow_ctrl
    import pswallow_pkg::*;
#(
    parameter int A_W = 3,
    parameter int M_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_in,
    input  logic [M_W-1:0] m_in,
    input  logic           word_ok,
    input  logic           tick,
    output logic           long_mode,
    output logic           restart_pre,
    output logic           pulse,
    output logic           bad
);
    div_state_t     state;
    div_state_t     state_d;
    logic [A_W-1:0] sw_left;
    logic [M_W-1:0] m_cnt;
    logic [M_W-1:0] act_m;
    logic           at_last;
    logic           load;

    assign at_last = (m_cnt == (act_m - M_W'(1)));
    assign load    = rst || (state == ST_HOLD) || (tick && at_last);

    // next-state logic
    always_comb begin
        state_d = state;
        if (load) begin
            if (!word_ok) begin
                state_d = ST_HOLD;
            end else if (a_in != '0) begin
                state_d = ST_SWALLOW;
            end else begin
                state_d = ST_PLAIN;
            end
        end else begin
            unique case (state)
                ST_SWALLOW: if (tick && (sw_left == A_W'(1))) state_d = ST_PLAIN;
                ST_PLAIN:   state_d = ST_PLAIN;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state <= state_d;
    end

    // counters and latched main count
    always_ff @(posedge clk) begin
        if (load) begin
            act_m   <= m_in;
            sw_left <= a_in;
            m_cnt   <= '0;
        end else if (tick) begin
            m_cnt <= m_cnt + M_W'(1);
            if (state == ST_SWALLOW) begin
                sw_left <= sw_left - A_W'(1);
            end
        end
    end

    // outputs
    assign long_mode   = (state_d == ST_SWALLOW);
    assign restart_pre = rst || (state == ST_HOLD);

    always_comb begin
        pulse = 1'b0;
        bad   = 1'b0;
        unique case (state)
            ST_HOLD:    bad = 1'b1;
            ST_SWALLOW: pulse = tick && at_last && !rst;
            ST_PLAIN:   pulse = tick && at_last && !rst;
            default:    bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
    parameter int A_W = 3,
    parameter int M_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [A_W+M_W-1:0] div_word,
    output logic               pulse_out,
    output logic               cfg_bad
);
    logic [A_W-1:0] a_in;
    logic [M_W-1:0] m_in;
    logic           word_ok;
    logic           tick;
    logic           long_mode;
    logic           restart_pre;

    assign a_in = div_word[A_W-1:0];
    assign m_in = div_word[A_W+M_W-1:A_W];

    pswallow_cfg_chk #(.A_W(A_W), .M_W(M_W)) cfg_i (
        .a_val   (a_in),
        .m_val   (m_in),
        .word_ok (word_ok)
    );

    pswallow_prescaler #(.A_W(A_W)) pre_i (
        .clk       (clk),
        .restart   (restart_pre),
        .long_mode (long_mode),
        .tick      (tick)
    );

    pswallow_ctrl #(.A_W(A_W), .M_W(M_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .a_in        (a_in),
        .m_in        (m_in),
        .word_ok     (word_ok),
        .tick        (tick),
        .long_mode   (long_mode),
        .restart_pre (restart_pre),
        .pulse       (pulse_out),
        .bad         (cfg_bad)
    );

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
    parameter int A_W = 3,
    parameter int M_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [A_W+M_W-1:0] div_word,
    input logic               pulse_out,
    input logic               cfg_bad
);
    localparam int WW = A_W + M_W;
    localparam int GW = WW + 1;

    logic [GW-1:0] gap;
    logic [GW-1:0] exp_gap;
    logic          exp_ok;
    logic          have_prev;

    // independent spacing model: ratio taken from the word at each pulse edge
    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            exp_gap   <= '0;
            exp_ok    <= 1'b0;
            have_prev <= 1'b0;
        end else if (pulse_out) begin
            gap       <= GW'(1);
            exp_gap   <= (GW'(div_word[WW-1:A_W]) << A_W) + GW'(div_word[A_W-1:0]);
            exp_ok    <= (div_word[WW-1:A_W] != '0) &&
                         (GW'(div_word[A_W-1:0]) <= GW'(div_word[WW-1:A_W]));
            have_prev <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + GW'(1);
        end
    end

    assert_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (pulse_out && have_prev && exp_ok) |-> (gap == exp_gap));

    assert_narrow_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_out |=> !pulse_out);

    assert_quiet_when_bad_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> !pulse_out);

    assert_bad_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_bad) |-> (($past(div_word[WW-1:A_W]) == '0) ||
                            (GW'($past(div_word[A_W-1:0])) > GW'($past(div_word[WW-1:A_W])))));

    assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_bad) |-> !pulse_out);

endmodule

bind pswallow_div pswallow_div_chk #(.A_W(A_W), .M_W(M_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .div_word  (div_word),
    .pulse_out (pulse_out),
    .cfg_bad   (cfg_bad)
);

// File: tb/pswallow_div_tb_top.sv
module pswallow_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIM   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] div_word = 11'h008;
    logic        pulse_out;
    logic        cfg_bad;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pswallow_div dut_i (
        .clk       (clk),
        .rst       (rst),
        .div_word  (div_word),
        .pulse_out (pulse_out),
        .cfg_bad   (cfg_bad)
    );

    function automatic logic [10:0] mk(input int m, input int a);
        logic [7:0] mv;
        logic [2:0] av;
        mv = m[7:0];
        av = a[2:0];
        return {mv, av};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // counts negedges until pulse_out is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pulse_out !== 1'b1 && n < WAIT_LIM);
    endtask

    // reset with a word; ends at the negedge of the first clock after reset
    task automatic do_reset(input int m, input int a, input bit exp_bad);
        @(negedge clk);
        rst = 1'b1;
        div_word = mk(m, a);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(pulse_out === 1'b0, "R8 pulse low in reset", int'(pulse_out), 0);
        end
        chk(cfg_bad === exp_bad, "R5/R8 cfg_bad after reset", int'(cfg_bad), int'(exp_bad));
        rst = 1'b0;
    endtask

    task automatic t_ratio(input int m, input int a, input string req);
        int r;
        int n;
        r = 8 * m + a;
        do_reset(m, a, 1'b0);
        wait_pulse(n);
        chk(n == r - 1, "R3 first pulse", n, r - 1);
        @(negedge clk);
        chk(pulse_out === 1'b0, "R2 pulse one clock wide", int'(pulse_out), 0);
        wait_pulse(n);
        chk(n == r - 1, req, n + 1, r);
        wait_pulse(n);
        chk(n == r, req, n, r);
    endtask

    task automatic t_midchange();
        int n;
        do_reset(10, 2, 1'b0);
        wait_pulse(n);
        repeat (5) @(negedge clk);
        div_word = mk(3, 1);
        wait_pulse(n);
        chk(n == 82 - 5, "R6 old ratio completes", n + 5, 82);
        wait_pulse(n);
        chk(n == 25, "R6 new ratio after boundary", n, 25);
    endtask

    task automatic t_invalid();
        int n;
        int seen;
        int badlow;
        do_reset(6, 0, 1'b0);
        wait_pulse(n);
        repeat (4) @(negedge clk);
        div_word = mk(2, 5);
        wait_pulse(n);
        chk(n == 44, "R6 period before illegal word", n + 4, 48);
        @(negedge clk);
        chk(cfg_bad === 1'b1, "R5 cfg_bad after A>M", int'(cfg_bad), 1);
        seen = 0;
        badlow = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (pulse_out !== 1'b0) seen++;
            if (cfg_bad !== 1'b1) badlow++;
            if (i == 60) div_word = mk(0, 0);
        end
        chk(seen == 0, "R5 no pulses while illegal", seen, 0);
        chk(badlow == 0, "R5 cfg_bad held", badlow, 0);
        div_word = mk(4, 4);
        @(negedge clk);
        chk(cfg_bad === 1'b0, "R7 cfg_bad clears", int'(cfg_bad), 0);
        wait_pulse(n);
        chk(n == 36 - 1, "R7 first pulse after recovery", n + 1, 36);
        wait_pulse(n);
        chk(n == 36, "R7 steady ratio after recovery", n, 36);
    endtask

    task automatic t_zero_main();
        int seen;
        do_reset(0, 0, 1'b1);
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pulse_out !== 1'b0) seen++;
        end
        chk(seen == 0, "R5 M=0 gives no pulses", seen, 0);
        chk(cfg_bad === 1'b1, "R5 M=0 flagged", int'(cfg_bad), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_ratio(1, 0, "R9 ratio 8");
        t_ratio(1, 1, "R9 ratio 9");
        t_ratio(12, 5, "R1 ratio 101");
        t_ratio(7, 7, "R4 A=M gives 9M");
        t_ratio(100, 0, "R4 A=0 gives 8M");
        t_ratio(255, 7, "R9 ratio 2047");
        t_midchange();
        t_invalid();
        t_zero_main();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule